// File: doc/BRIEF.md
# Watchdog and Start-up Reset Controller

This block supervises a small 8-bit controller core. A watchdog counter advances on a selectable tick, which is either every clock or a prescaled rate. If the core does not clear it in time, the counter expires and the block resets the core. The core clears the watchdog through two separate clear strobes. A mode input decides whether one strobe is enough or whether both must be seen, in either order, before a clear takes effect. Two status flags are kept for software. The timeout flag records that the watchdog expired. The power-down flag records that the core entered halt.

After an asynchronous reset, a watchdog expiry or a wake-up, a start-up timer keeps the core in reset until the oscillator has had time to settle. During halt the core clock is gated off through the run enable. The watchdog keeps counting in halt. If it expires there, the core is woken through the start-up hold and is not fully reset, so the power-down flag survives.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: While `rst_ni` is low, `core_rst_o`=1, `run_en_o`=0, `to_o`=0 and `pdf_o`=0. After `rst_ni` is released, `core_rst_o` stays high for exactly SST_CYCLES (default 1024) clock cycles. `run_en_o` then rises.
- R2: With the tick on every cycle (`opt_slow_clk_i`=0) and no clear, `run_en_o` stays high for exactly 2**WDT_LOG2 (default 64) cycles. Then `core_rst_o` rises, `to_o` becomes 1, `pdf_o` keeps its value, and a full start-up hold follows.
- R3: With `opt_dual_clr_i`=0, a one-cycle pulse on either `wdt_clr_a_i` or `wdt_clr_b_i` alone, while running, restarts the full timeout period.
- R4: With `opt_dual_clr_i`=1, a clear takes effect only once both strobes have been seen since the last effective clear, in either order. Repeated pulses on one strobe never restart the period.
- R5: An effective clear drives `to_o` and `pdf_o` to 0. A strobe that does not take effect leaves both flags unchanged.
- R6: A half-finished dual clear, where only one strobe has been seen, is forgotten on every reset: asynchronous reset, watchdog expiry or wake-up.
- R7: `halt_req_i` while running drops `run_en_o` in the next cycle without asserting `core_rst_o`, and sets `pdf_o`. The watchdog keeps counting through halt.
- R8: `wake_i` during halt asserts `core_rst_o` in the next cycle for a full start-up hold. `pdf_o` and `to_o` keep their values.
- R9: Watchdog expiry during halt sets `to_o`, keeps `pdf_o` at 1, and enters a full start-up hold.
- R10: `opt_wdt_off_i`=1 holds the watchdog count at zero and no timeout occurs. After it is released, a full period elapses before expiry.
- R11: With `opt_slow_clk_i`=1, the watchdog advances once every 2**PRESC_LOG2 (default 4) cycles. The prescaler restarts in each hold, so the run period is 2**(WDT_LOG2+PRESC_LOG2) (default 256) cycles.
- R12: Clear strobes are ignored outside the running state. A strobe seen during halt does not postpone an expiry in halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdt_clr_a_i | input | 1 | First watchdog clear strobe |
| wdt_clr_b_i | input | 1 | Second watchdog clear strobe |
| halt_req_i | input | 1 | Core requests power-down halt |
| wake_i | input | 1 | Wake event while halted |
| opt_dual_clr_i | input | 1 | 1: both strobes needed to clear |
| opt_wdt_off_i | input | 1 | 1: watchdog held at zero |
| opt_slow_clk_i | input | 1 | 1: watchdog advances on the prescaled tick |
| core_rst_o | output | 1 | Reset to the core (start-up hold) |
| to_o | output | 1 | Timeout status flag |
| pdf_o | output | 1 | Power-down status flag |
| run_en_o | output | 1 | Core clock enable |

## Verification
The bench measures exact hold and run lengths in cycles. A start-up timer that is off by one, or a watchdog that expires a period early or late, therefore shows up as a wrong count. It checks that one strobe alone never clears the watchdog in dual mode. It also checks that a first strobe left pending before an expiry, a wake-up or an asynchronous reset cannot pair with a later second strobe; a design that kept the pending record would stretch the next run by one cycle. Strobes are pulsed during halt, where a design that honoured them would push the halt expiry later. The bench also checks that the power-down flag survives both a wake and an expiry in halt.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_RUN  = 2'd1,
    PH_HALT = 2'd2
  } phase_e;

  // Clear qualification: single mode takes any strobe, dual mode needs
  // both strobes either now or remembered from an earlier cycle.
  function automatic logic clear_qualify(input logic dual, input logic a,
                                         input logic b, input logic pa,
                                         input logic pb);
    if (dual) return (a | pa) & (b | pb);
    return a | b;
  endfunction

  // Phase sequencing: expiry dominates, then halt or wake.
  function automatic phase_e next_phase(input phase_e cur, input logic sst_done,
                                        input logic expire, input logic halt_req,
                                        input logic wake);
    case (cur)
      PH_HOLD: return sst_done ? PH_RUN : PH_HOLD;
      PH_RUN:  return expire ? PH_HOLD : (halt_req ? PH_HALT : PH_RUN);
      PH_HALT: return (expire | wake) ? PH_HOLD : PH_HALT;
      default: return PH_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/wdr_tick_gen.sv
module wdr_tick_gen #(
  parameter int unsigned PRESC_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic slow_sel_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESC_LOG2 < 1) ? 1 : PRESC_LOG2;

  logic [PW-1:0] presc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        presc_q <= '0;
    else if (restart_i) presc_q <= '0;
    else                presc_q <= presc_q + 1'b1;
  end

  assign tick_o = slow_sel_i ? (&presc_q) : 1'b1;
endmodule

// File: rtl/wdr_clear_arb.sv
module wdr_clear_arb
  import wdr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic flush_i,
  input  logic dual_i,
  input  logic a_i,
  input  logic b_i,
  output logic take_o
);
  logic pend_a_q, pend_b_q;

  assign take_o = run_i & clear_qualify(dual_i, a_i, b_i, pend_a_q, pend_b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else if (flush_i || take_o) begin
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else if (run_i && dual_i) begin
      pend_a_q <= pend_a_q | a_i;
      pend_b_q <= pend_b_q | b_i;
    end
  end
endmodule

// File: rtl/wdr_divider.sv
module wdr_divider #(
  parameter int unsigned WDT_LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic off_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic expire_o
);
  logic [WDT_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!active_i || off_i || clr_i) cnt_q <= '0;
    else if (tick_i)                      cnt_q <= cnt_q + 1'b1;
  end

  // A clear in the same cycle wins over the final tick.
  assign expire_o = active_i & ~off_i & ~clr_i & tick_i & (&cnt_q);
endmodule

// File: rtl/wdr_startup.sv
module wdr_startup #(
  parameter int unsigned SST_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic done_o
);
  localparam int unsigned SW = $clog2(SST_CYCLES);
  localparam logic [SW-1:0] LAST = SW'(SST_CYCLES - 1);

  logic [SW-1:0] cnt_q;

  assign done_o = hold_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!hold_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl
  import wdr_pkg::*;
#(
  parameter int unsigned WDT_LOG2   = 6,
  parameter int unsigned SST_CYCLES = 1024,
  parameter int unsigned PRESC_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_clr_a_i,
  input  logic wdt_clr_b_i,
  input  logic halt_req_i,
  input  logic wake_i,
  input  logic opt_dual_clr_i,
  input  logic opt_wdt_off_i,
  input  logic opt_slow_clk_i,
  output logic core_rst_o,
  output logic to_o,
  output logic pdf_o,
  output logic run_en_o
);
  phase_e phase_q, phase_d;
  logic in_hold, in_run, in_halt;
  logic tick, clr_take, wdt_expire, sst_done, halt_enter;
  logic to_q, pdf_q;

  assign in_hold = (phase_q == PH_HOLD);
  assign in_run  = (phase_q == PH_RUN);
  assign in_halt = (phase_q == PH_HALT);

  wdr_tick_gen #(.PRESC_LOG2(PRESC_LOG2)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(in_hold),
    .slow_sel_i(opt_slow_clk_i), .tick_o(tick)
  );

  wdr_clear_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_run), .flush_i(in_hold),
    .dual_i(opt_dual_clr_i), .a_i(wdt_clr_a_i), .b_i(wdt_clr_b_i),
    .take_o(clr_take)
  );

  wdr_divider #(.WDT_LOG2(WDT_LOG2)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(in_run | in_halt),
    .off_i(opt_wdt_off_i), .tick_i(tick), .clr_i(clr_take),
    .expire_o(wdt_expire)
  );

  wdr_startup #(.SST_CYCLES(SST_CYCLES)) u_sst (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(in_hold), .done_o(sst_done)
  );

  assign halt_enter = in_run & halt_req_i & ~wdt_expire;

  always_comb begin
    phase_d = next_phase(phase_q, sst_done, wdt_expire, halt_req_i, wake_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HOLD;
      to_q    <= 1'b0;
      pdf_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (wdt_expire)    to_q <= 1'b1;
      else if (clr_take) to_q <= 1'b0;
      if (halt_enter)    pdf_q <= 1'b1;
      else if (clr_take) pdf_q <= 1'b0;
    end
  end

  assign core_rst_o = in_hold;
  assign run_en_o   = in_run;
  assign to_o       = to_q;
  assign pdf_o      = pdf_q;
endmodule

// File: rtl/wdr_checker.sv
module wdr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic a_i,
  input logic b_i,
  input logic halt_req_i,
  input logic wake_i,
  input logic dual_i,
  input logic off_i,
  input logic in_run,
  input logic in_halt,
  input logic clr_take,
  input logic wdt_expire,
  input logic halt_enter,
  input logic core_rst_o,
  input logic run_en_o,
  input logic to_o,
  input logic pdf_o
);
  assert_hold_blocks_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> !run_en_o);

  assert_expire_resets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_expire |=> (core_rst_o && to_o));

  assert_single_any_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_run && !dual_i && (a_i || b_i)) |-> clr_take);

  assert_take_needs_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_take |-> (a_i || b_i));

  assert_clear_drops_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_take && !halt_enter) |=> (!to_o && !pdf_o));

  assert_halt_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_run && halt_req_i && !wdt_expire) |=> (pdf_o && !run_en_o && !core_rst_o));

  assert_wake_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_halt && wake_i && !wdt_expire) |=> (core_rst_o && pdf_o));

  assert_halt_expire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_halt && wdt_expire) |=> (core_rst_o && to_o && pdf_o));

  assert_off_no_expire_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |-> !wdt_expire);

  assert_idle_ignores_strobes_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_run |-> !clr_take);
endmodule

bind wdog_rst_ctrl wdr_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(wdt_clr_a_i), .b_i(wdt_clr_b_i),
  .halt_req_i(halt_req_i), .wake_i(wake_i), .dual_i(opt_dual_clr_i),
  .off_i(opt_wdt_off_i), .in_run(in_run), .in_halt(in_halt),
  .clr_take(clr_take), .wdt_expire(wdt_expire), .halt_enter(halt_enter),
  .core_rst_o(core_rst_o), .run_en_o(run_en_o), .to_o(to_o), .pdf_o(pdf_o)
);

// File: tb/wdog_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module wdog_rst_ctrl_tb_top;
  localparam int HOLD_LEN = 1024;
  localparam int RUN_LEN  = 64;
  localparam int SLOW_LEN = 256;

  logic clk = 1'b0;
  logic rst_ni, clr_a, clr_b, halt_req, wake, opt_dual, opt_off, opt_slow;
  logic core_rst, to_f, pdf_f, run_en;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  wdog_rst_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wdt_clr_a_i(clr_a), .wdt_clr_b_i(clr_b),
    .halt_req_i(halt_req), .wake_i(wake), .opt_dual_clr_i(opt_dual),
    .opt_wdt_off_i(opt_off), .opt_slow_clk_i(opt_slow),
    .core_rst_o(core_rst), .to_o(to_f), .pdf_o(pdf_f), .run_en_o(run_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure_hold(output int n);
    n = 0;
    while (core_rst && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic measure_run(output int n);
    n = 0;
    while (run_en && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic pulse_a; clr_a = 1'b1; @(negedge clk); clr_a = 1'b0; endtask
  task automatic pulse_b; clr_b = 1'b1; @(negedge clk); clr_b = 1'b0; endtask

  task automatic t_reset;
    int n;
    check_eq("R1", "core_rst in reset", core_rst, 1);
    check_eq("R1", "run_en in reset", run_en, 0);
    check_eq("R1", "to in reset", to_f, 0);
    check_eq("R1", "pdf in reset", pdf_f, 0);
    rst_ni = 1'b1;
    measure_hold(n);
    check_eq("R1", "start-up hold length", n, HOLD_LEN);
  endtask

  task automatic t_timeout;
    int n;
    measure_run(n);
    check_eq("R2", "run length without clear", n, RUN_LEN);
    check_eq("R2", "to after expiry", to_f, 1);
    check_eq("R2", "pdf after expiry", pdf_f, 0);
    measure_hold(n);
    check_eq("R2", "hold after expiry", n, HOLD_LEN);
  endtask

  task automatic t_single;
    int n; int ok;
    pulse_a;
    check_eq("R5", "to after effective clear", to_f, 0);
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      repeat (20) begin @(negedge clk); if (!run_en) ok = 0; end
      if (i % 2 == 1) pulse_a; else pulse_b;
    end
    check_eq("R3", "single strobes keep core running", ok, 1);
    measure_run(n);
    check_eq("R3", "full period after last strobe", n, RUN_LEN);
    measure_hold(n);
  endtask

  task automatic t_dual;
    int n;
    opt_dual = 1'b1;
    pulse_a;
    repeat (20) @(negedge clk);
    pulse_a;
    check_eq("R5", "to kept by ineffective strobe", to_f, 1);
    measure_run(n);
    check_eq("R4", "A-only strobes do not restart", n, RUN_LEN - 22);
    measure_hold(n);
    pulse_b;
    repeat (30) @(negedge clk);
    check_eq("R4", "to after lone B", to_f, 1);
    pulse_a;
    check_eq("R5", "to after B then A", to_f, 0);
    measure_run(n);
    check_eq("R4", "B then A restarts period", n, RUN_LEN);
    measure_hold(n);
    pulse_a;
    repeat (10) @(negedge clk);
    pulse_b;
    measure_run(n);
    check_eq("R4", "A then B restarts period", n, RUN_LEN);
    measure_hold(n);
  endtask

  task automatic t_pending;
    int n;
    pulse_a;
    measure_run(n);
    check_eq("R4", "lone A before expiry", n, RUN_LEN - 1);
    measure_hold(n);
    pulse_b;
    measure_run(n);
    check_eq("R6", "pending A dropped by expiry", n, RUN_LEN - 1);
    check_eq("R6", "to after lone B", to_f, 1);
    measure_hold(n);
    pulse_a;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    measure_hold(n);
    check_eq("R1", "hold after async reset", n, HOLD_LEN);
    pulse_b;
    measure_run(n);
    check_eq("R6", "pending A dropped by async reset", n, RUN_LEN - 1);
    measure_hold(n);
    opt_dual = 1'b0;
  endtask

  task automatic t_halt_wake;
    int n;
    pulse_a;
    repeat (3) @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    check_eq("R7", "run_en in halt", run_en, 0);
    check_eq("R7", "core_rst in halt", core_rst, 0);
    check_eq("R7", "pdf in halt", pdf_f, 1);
    repeat (10) @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check_eq("R8", "core_rst after wake", core_rst, 1);
    check_eq("R8", "pdf after wake", pdf_f, 1);
    check_eq("R8", "to after wake", to_f, 0);
    measure_hold(n);
    check_eq("R8", "hold after wake", n, HOLD_LEN);
    check_eq("R8", "pdf after wake hold", pdf_f, 1);
  endtask

  task automatic t_halt_expire;
    int n;
    pulse_a;
    check_eq("R5", "pdf after clear", pdf_f, 0);
    repeat (3) @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    n = 0;
    while (!core_rst && n < 5000) begin
      clr_a = (n == 0);
      n++;
      @(negedge clk);
    end
    clr_a = 1'b0;
    check_eq("R12", "halt cycles before expiry (strobe ignored)", n, RUN_LEN - 4);
    check_eq("R9", "to after halt expiry", to_f, 1);
    check_eq("R9", "pdf after halt expiry", pdf_f, 1);
    measure_hold(n);
    check_eq("R9", "hold after halt expiry", n, HOLD_LEN);
  endtask

  task automatic t_off_slow;
    int n; int ok;
    opt_off = 1'b1;
    ok = 1;
    repeat (300) begin @(negedge clk); if (!run_en) ok = 0; end
    check_eq("R10", "no timeout while off", ok, 1);
    opt_off = 1'b0;
    measure_run(n);
    check_eq("R10", "full period after release", n, RUN_LEN);
    opt_slow = 1'b1;
    measure_hold(n);
    measure_run(n);
    check_eq("R11", "slow tick run length", n, SLOW_LEN);
    check_eq("R11", "to after slow expiry", to_f, 1);
  endtask

  initial begin
    rst_ni = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halt_req = 1'b0; wake = 1'b0;
    opt_dual = 1'b0; opt_off = 1'b0; opt_slow = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    t_timeout;
    t_single;
    t_dual;
    t_pending;
    t_halt_wake;
    t_halt_expire;
    t_off_slow;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule